// File: doc/BRIEF.md
# Dual-Mode Power-Fail Supervisor Sequencer

This block sequences the supervisory outputs of a processor board from three comparator flags that are already digitized and synchronized to the block clock. The first flag says the monitored input is below its threshold. The second says VCC is below its trip point. The third says VCC is below battery level. From these flags the block drives an early-warning interrupt (active low, with an output enable), a reset pair, a RAM chip-enable gate and a power-fail pair.

A static mode input selects between two behaviours. In NMOS mode a VCC trip asserts reset and releases the interrupt line. In CMOS mode the processor is only warned, and no reset is issued until the monitored input has recovered.

A reset-hold timer stretches every reset to a fixed number of cycles. A watchdog forces a reset when the processor stops toggling its strobe. All timeouts are parameters, counted in clock cycles. Every output is a function of registered state, so it changes one clock after the flag that causes it.

Top module: `pf_supervisor`

## Requirements
- R1: While `rst_n` is low, the block is in the powered-down state. It shows `ce_block`=1, `pf`=0, `pf_n`=1 and `nmi_n`=1. The reset pair is asserted and `nmi_oe`=0 when `cmos_sel`=0 (NMOS). The reset pair is released and `nmi_oe`=1 when `cmos_sel`=1 (CMOS).
- R2: In the running state, each 0-to-1 change of `in_low` drives `nmi_n` low for exactly `NMI_CYC` cycles, starting one clock later. Holding `in_low` high gives no further pulse. A new rise gives a new pulse.
- R3: `ce_block` equals `vcc_low` delayed by one clock, in both modes. A value of 1 write-protects the RAM.
- R4: `pf` equals `vcc_batt` delayed by one clock, and `pf_n` is always its complement.
- R5: In NMOS mode, `vcc_low`=1 asserts `rst_hi`=1 one clock later and sets `nmi_oe`=0. Both hold while the flag stays high.
- R6: In CMOS mode, `vcc_low`=1 never asserts reset, and `nmi_oe` stays 1.
- R7: On NMOS power-up, the clock that samples `vcc_low`=0 starts a reset lasting exactly `RST_CYC` cycles and an `NMI_CYC`-cycle interrupt pulse.
- R8: On CMOS power-up, reset stays released while `in_low`=1. The first clock that samples both `vcc_low`=0 and `in_low`=0 starts a reset of exactly `RST_CYC` cycles, with no interrupt pulse.
- R9: In the running state, if `strobe` does not change for `WD_CYC` cycles, a reset of `RST_CYC` cycles follows. Any change of `strobe`, rising or falling, restarts the count.
- R10: If a watchdog expiry and `vcc_low`=1 fall on the same clock, the VCC trip wins. The block enters the powered-down state with that mode's output levels, not the watchdog reset.
- R11: `cmos_sel` is captured only while `rst_n` is low or the reset-hold timer runs. Changing it in the running state has no effect on the next power-down.
- R12: `rst_lo_n` is always the complement of `rst_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmos_sel | input | 1 | Mode select: 1 = CMOS behaviour, 0 = NMOS behaviour |
| in_low | input | 1 | Monitored input is below its threshold |
| vcc_low | input | 1 | VCC is below its trip point |
| vcc_batt | input | 1 | VCC is below battery level |
| strobe | input | 1 | Watchdog strobe from the processor; any edge counts |
| nmi_n | output | 1 | Early-warning interrupt, active low |
| nmi_oe | output | 1 | Output enable of the interrupt pin; 0 means high impedance |
| rst_hi | output | 1 | Processor reset, active high |
| rst_lo_n | output | 1 | Processor reset, active low |
| ce_block | output | 1 | RAM chip-enable gate; 1 forces the enable inactive |
| pf | output | 1 | Power-fail flag, active high |
| pf_n | output | 1 | Power-fail flag, active low |

## Verification
The watchdog expiry and the VCC trip can land on the same clock edge. The bench provokes this by letting the watchdog run unstrobed to its last cycle, then raising `vcc_low` on exactly that edge. The outcome is judged in both modes by the interrupt enable and the reset level. In NMOS mode the powered-down state shows `nmi_oe`=0, whereas a watchdog reset would leave it at 1. In CMOS mode no reset at all appears. The same run also changes the mode input while running, to confirm that the trip follows the captured mode.

// File: rtl/pfs_pkg.sv
// Shared types for the power-fail supervisor.
// Assumes: nothing beyond the three sequencer states listed here.
package pfs_pkg;

    // Sequencer states: powered down, reset being held, processor running.
    typedef enum logic [1:0] {
        PS_DOWN = 2'd0,
        PS_HOLD = 2'd1,
        PS_RUN  = 2'd2
    } pfs_state_t;

endpackage

// File: rtl/pfs_cycle_timer.sv
// Cycle counter with synchronous clear. It pulses done on the
// LIMIT-th consecutive cycle without clear, then restarts from zero.
// Used both for the reset-hold time and for the watchdog window.
// Assumes: LIMIT >= 2.
module pfs_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign done = !clear && (cnt == LAST);

    // Count cycles; restart on clear or after reaching the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || done) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    a_r7_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) < LIMIT));

endmodule

// File: rtl/pfs_nmi_pulse.sv
// Fixed-width pulse generator for the early-warning interrupt.
// A fire request reloads the full width, even while a pulse is running.
// Assumes: WIDTH >= 1.
module pfs_nmi_pulse #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int W = $clog2(WIDTH + 1);

    logic [W-1:0] cnt;

    assign active = (cnt != '0);

    // Load on fire, otherwise count the pulse down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (fire)   cnt <= W'(WIDTH);
        else if (active) cnt <= cnt - 1'b1;
    end

    a_r2_nmi_reload: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (int'(cnt) == WIDTH));

endmodule

// File: rtl/pf_supervisor.sv
// Power-fail supervisor sequencer.
// Watches three synchronized comparator flags and drives the interrupt,
// reset, RAM-gate and power-fail outputs. NMOS or CMOS behaviour is set
// by cmos_sel, which is captured only while reset is active.
// Assumes: the flags are synchronous to clk; timeouts are in clock cycles.
module pf_supervisor #(
    parameter int RST_CYC = 200,
    parameter int WD_CYC  = 1000,
    parameter int NMI_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmos_sel,
    input  logic in_low,
    input  logic vcc_low,
    input  logic vcc_batt,
    input  logic strobe,
    output logic nmi_n,
    output logic nmi_oe,
    output logic rst_hi,
    output logic rst_lo_n,
    output logic ce_block,
    output logic pf,
    output logic pf_n
);
    import pfs_pkg::*;

    pfs_state_t st, st_nxt;
    logic mode_q;
    logic in_q, strobe_q;
    logic ce_q, pf_q;
    logic hold_done, wd_done, kick, nmi_fire, nmi_act;
    logic past_ok;

    assign kick = strobe ^ strobe_q;

    // Next state; a VCC trip outranks both timers.
    always_comb begin
        st_nxt = st;
        case (st)
            PS_DOWN: if (!vcc_low && (!mode_q || !in_low)) st_nxt = PS_HOLD;
            PS_HOLD: if (vcc_low) st_nxt = PS_DOWN;
                     else if (hold_done) st_nxt = PS_RUN;
            PS_RUN:  if (vcc_low) st_nxt = PS_DOWN;
                     else if (wd_done) st_nxt = PS_HOLD;
            default: st_nxt = PS_DOWN;
        endcase
    end

    // Interrupt request: a new fall of the input while running,
    // or an NMOS power-up.
    assign nmi_fire = (st == PS_RUN && in_low && !in_q) ||
                      (st == PS_DOWN && st_nxt == PS_HOLD && !mode_q);

    // State register and mode capture (only while reset is active).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PS_DOWN;
            mode_q <= cmos_sel;
        end else begin
            st <= st_nxt;
            if (st == PS_HOLD) mode_q <= cmos_sel;
        end
    end

    // Edge-detect history and registered flag followers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q     <= 1'b0;
            strobe_q <= 1'b0;
            ce_q     <= 1'b1;
            pf_q     <= 1'b0;
        end else begin
            in_q     <= in_low;
            strobe_q <= strobe;
            ce_q     <= vcc_low;
            pf_q     <= vcc_batt;
        end
    end

    pfs_cycle_timer #(.LIMIT(RST_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .clear(st != PS_HOLD), .done(hold_done)
    );

    pfs_cycle_timer #(.LIMIT(WD_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .clear((st != PS_RUN) || kick), .done(wd_done)
    );

    pfs_nmi_pulse #(.WIDTH(NMI_CYC)) u_nmi (
        .clk(clk), .rst_n(rst_n), .fire(nmi_fire), .active(nmi_act)
    );

    assign rst_hi   = (st == PS_HOLD) || (st == PS_DOWN && !mode_q);
    assign rst_lo_n = !rst_hi;
    assign nmi_n    = !nmi_act;
    assign nmi_oe   = !(st == PS_DOWN && !mode_q);
    assign ce_block = ce_q;
    assign pf       = pf_q;
    assign pf_n     = !pf_q;

    // Marks cycles whose previous edge was outside reset (assertions only).
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r3_ce_follows: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (ce_block == $past(vcc_low)));

    a_r4_pf_follows: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (pf == $past(vcc_batt) && pf_n != pf));

    a_r5_nmos_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !mode_q && !$past(mode_q) && $past(vcc_low)) |-> (rst_hi && !nmi_oe));

    a_r6_cmos_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode_q && $past(mode_q) && $past(vcc_low)) |-> (!rst_hi && nmi_oe));

    a_r8_cmos_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode_q && $past(mode_q) && $past(st) == PS_DOWN && $past(in_low)) |-> !rst_hi);

    a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && st == PS_RUN && $past(st) == PS_RUN) |-> $stable(mode_q));

    a_r12_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_hi) |-> $fell(rst_lo_n));

endmodule

// File: tb/pf_supervisor_test.sv
module pf_supervisor_test;
    localparam int RC = 4;
    localparam int WC = 20;
    localparam int NW = 3;

    logic clk = 1'b0;
    logic rst_n, cmos_sel, in_low, vcc_low, vcc_batt, strobe;
    logic nmi_n, nmi_oe, rst_hi, rst_lo_n, ce_block, pf, pf_n;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pf_supervisor #(.RST_CYC(RC), .WD_CYC(WC), .NMI_CYC(NW)) uut (
        .clk(clk), .rst_n(rst_n), .cmos_sel(cmos_sel), .in_low(in_low),
        .vcc_low(vcc_low), .vcc_batt(vcc_batt), .strobe(strobe),
        .nmi_n(nmi_n), .nmi_oe(nmi_oe), .rst_hi(rst_hi), .rst_lo_n(rst_lo_n),
        .ce_block(ce_block), .pf(pf), .pf_n(pf_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Checks the reset pair together (R12 is covered on every call).
    task automatic chk_rst(string req, int exp);
        chk(req, rst_hi, exp);
        chk({req, " R12 rst_lo_n"}, rst_lo_n, 1 - exp);
    endtask

    // Counts reset-high samples (and interrupt-low samples among them).
    task automatic count_reset(output int n, output int k);
        n = 0; k = 0;
        while (rst_hi && n < 100) begin
            if (!nmi_n) k++;
            n++;
            tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, k;
        for (int m = 0; m < 2; m++) begin
            rst_n = 0; cmos_sel = m[0]; vcc_low = 1; vcc_batt = 1; in_low = 1; strobe = 0;
            tick(); tick();
            // R1: reset state in this mode
            chk_rst("R1 reset", 1 - m);
            chk("R1 ce_block", ce_block, 1);
            chk("R1 pf", pf, 0);
            chk("R1 pf_n", pf_n, 1);
            chk("R1 nmi_n", nmi_n, 1);
            chk("R1 nmi_oe", nmi_oe, m);
            rst_n = 1; tick();
            chk("R4 pf at battery", pf, 1);
            chk("R4 pf_n at battery", pf_n, 0);
            vcc_batt = 0; tick();
            chk("R4 pf cleared", pf, 0);
            chk("R4 pf_n cleared", pf_n, 1);
            if (m == 0) begin
                vcc_low = 0; in_low = 0; tick();
                chk("R3 ce released", ce_block, 0);
                count_reset(n, k);
                chk("R7 nmos reset length", n, RC);
                chk("R7 nmos powerup nmi", k, NW);
            end else begin
                vcc_low = 0; tick();
                chk("R3 ce released", ce_block, 0);
                for (int i = 0; i < 3; i++) begin
                    chk_rst("R8 cmos waits for input", 0);
                    tick();
                end
                in_low = 0; tick();
                count_reset(n, k);
                chk("R8 cmos reset length", n, RC);
                chk("R8 cmos no nmi", k, 0);
            end
            // R9: unstrobed watchdog window, then a reset of RC cycles
            n = 0;
            while (!rst_hi && n < 100) begin n++; tick(); end
            chk("R9 watchdog window", n, WC);
            count_reset(n, k);
            chk("R9 watchdog reset length", n, RC);
            // R11: flip mode while running; R10: trip on the expiry edge
            cmos_sel = ~m[0];
            repeat (WC - 1) tick();
            chk_rst("R9 last window cycle", 0);
            vcc_low = 1; tick();
            chk_rst("R10 trip wins over watchdog", 1 - m);
            chk("R10 nmi_oe shows powered-down", nmi_oe, m);
            chk("R3 ce protect", ce_block, 1);
            repeat (RC + 2) tick();
            chk_rst(m == 0 ? "R5 nmos reset held" : "R6 cmos no reset", 1 - m);
            chk("R11 mode kept nmi_oe", nmi_oe, m);
            vcc_batt = 1; tick();
            chk("R4 pf on battery", pf, 1);
            chk("R4 pf_n on battery", pf_n, 0);
            vcc_batt = 0; cmos_sel = m[0]; tick();
            chk("R4 pf off battery", pf, 0);
            vcc_low = 0; tick();
            count_reset(n, k);
            chk(m == 0 ? "R7 second powerup length" : "R8 second powerup length", n, RC);
            chk(m == 0 ? "R7 second powerup nmi" : "R8 second powerup nmi", k, (m == 0) ? NW : 0);
            // R2: interrupt pulses while running, strobing to hold off the watchdog
            in_low = 1; strobe = ~strobe; tick();
            n = 0;
            while (!nmi_n && n < 50) begin n++; strobe = ~strobe; tick(); end
            chk("R2 pulse width", n, NW);
            k = 0;
            for (int i = 0; i < 3; i++) begin
                if (!nmi_n) k++;
                strobe = ~strobe; tick();
            end
            chk("R2 no refire while held", k, 0);
            in_low = 0; strobe = ~strobe; tick();
            in_low = 1; strobe = ~strobe; tick();
            n = 0;
            while (!nmi_n && n < 50) begin n++; strobe = ~strobe; tick(); end
            chk("R2 fresh pulse width", n, NW);
            chk_rst("R9 strobes hold off reset", 0);
            // R9: strobe edges every 5 cycles keep reset released
            k = 0;
            for (int i = 0; i < 3 * WC; i++) begin
                if (i % 5 == 0) strobe = ~strobe;
                tick();
                if (rst_hi) k++;
            end
            chk("R9 restart on any edge", k, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule